// File: doc/BRIEF.md
# Rate-Limited Duty Ramp Controller

This block holds a small level code, from 0 to 11, that selects one of the steps of a downstream duty level generator. Level 0 is the lowest duty step and level 11 is full duty. The level follows an external measurement. One compare bit says whether the measured duty is above the duty that the current level represents. The level climbs toward the target slowly and falls quickly. A programmable divider paces each change by counting pulses of an input tick.

When the level is rising, the divider waits a user-selected number of ticks between steps: 66, 132, 198 or 264. When it is falling, it waits 4 ticks. Two speed-band flags change this behaviour:
- A low-band flag forces the level down to its floor.
- A high-band flag makes every step use the short interval.

A test-mode select swaps the normal once-per-waveform-period tick for a tick that runs sixteen times as often, so every ramp runs sixteen times faster.

Whenever the direction reverses, the divider restarts. The first step in the new direction therefore takes a full interval.

Top module: `dramp_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, `level_o` is 0.
- R2: With both band flags low and `duty_above_i`=1, the level rises by one after every N selected ticks. N is 264 for `rate_code_i`=2'b00, 198 for 2'b01, 132 for 2'b10 and 66 for 2'b11.
- R3: With both band flags low and `duty_above_i`=0, the level falls by one after every 4 selected ticks.
- R4: With `band_high_i`=1 and `band_low_i`=0, the direction still follows `duty_above_i`, but every step needs only 4 selected ticks, whatever the rate code.
- R5: With `band_low_i`=1, the level never rises, whatever `duty_above_i` and the rate code are. It falls by one every 4 selected ticks.
- R6: The level never goes below 0 or above 11. A down step at 0 and an up step at 11 leave it unchanged.
- R7: With `test_mode_i`=0, only `period_tick_i` pulses are counted. With `test_mode_i`=1, only `fast_tick_i` pulses are counted. Pulses on the unselected tick input have no effect.
- R8: When the direction changes, the tick count restarts from zero. The first step in the new direction comes only after a full interval.
- R9: A step takes effect at the rising clock edge that samples the completing tick. `level_o` is a register, so the new value is visible in the cycle right after that tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| period_tick_i | input | 1 | One-cycle pulse once per waveform period (normal pacing) |
| fast_tick_i | input | 1 | One-cycle pulse sixteen times as often (test pacing) |
| test_mode_i | input | 1 | 1 selects `fast_tick_i` as the pacing tick |
| rate_code_i | input | 2 | Rise interval select: 00=264, 01=198, 10=132, 11=66 ticks |
| duty_above_i | input | 1 | 1 when the measured duty exceeds the duty of the current level |
| band_low_i | input | 1 | Speed below the low threshold: forces the direction down |
| band_high_i | input | 1 | Speed above the high threshold: forces a 4-tick interval |
| level_o | output | 4 | Current level code, 0 to 11 |

## Verification
A direction change is taken up at the first clock edge after the inputs move, and it clears the tick count there. Each level step then appears in the cycle after the tick that completes the interval. The driver holds each tick high for exactly one sampled edge. It pushes the expected level once the pulse's completing edge has passed, and the monitor compares `level_o` at the next falling edge. That edge lies after the register update and before the driver touches any input again. The interval boundaries are probed one tick short and then at the exact tick count, so a divider that steps one tick early or late is reported.

// File: rtl/dramp_pkg.sv
package dramp_pkg;

    // Direction of the level counter
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    // Pacing request handed from the divider to the level register
    typedef struct packed {
        logic step;
        dir_e dir;
    } step_cmd_t;

    // Default geometry of the block
    localparam int DEF_LVL_W    = 4;
    localparam int DEF_LVL_TOP  = 11;
    localparam int DEF_UNIT_DIV = 66;
    localparam int DEF_DOWN_DIV = 4;

    // Rise interval in ticks for a rate code: slowest at 00, fastest at 11
    function automatic int rise_ticks(input logic [1:0] code, input int unit_div);
        return unit_div * (4 - int'(code));
    endfunction

endpackage

// File: rtl/dramp_dir_sel.sv
module dramp_dir_sel
    import dramp_pkg::*;
#(
    parameter int CNT_W    = 9,
    parameter int UNIT_DIV = DEF_UNIT_DIV,
    parameter int DOWN_DIV = DEF_DOWN_DIV
) (
    input  logic             band_low_i,
    input  logic             band_high_i,
    input  logic             duty_above_i,
    input  logic [1:0]       rate_code_i,
    output dir_e             dir_o,
    output logic [CNT_W-1:0] ratio_o
);

    dir_e dir_w;

    // Low band wins over the compare bit
    always_comb begin
        if (band_low_i) begin
            dir_w = DIR_DOWN;
        end else if (duty_above_i) begin
            dir_w = DIR_UP;
        end else begin
            dir_w = DIR_DOWN;
        end
    end

    // Short interval for every fall and for any step in the high band
    always_comb begin
        if (band_high_i || (dir_w == DIR_DOWN)) begin
            ratio_o = CNT_W'(DOWN_DIV);
        end else begin
            ratio_o = CNT_W'(rise_ticks(rate_code_i, UNIT_DIV));
        end
    end

    assign dir_o = dir_w;

endmodule

// File: rtl/dramp_pacer.sv
module dramp_pacer
    import dramp_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  dir_e             dir_i,
    input  logic [CNT_W-1:0] ratio_i,
    output step_cmd_t        cmd_o
);

    logic [CNT_W-1:0] cnt_q;
    dir_e             dir_q;
    logic             restart;
    logic             last;

    assign restart = (dir_i != dir_q);
    // ">=" also closes an interval cut short by a smaller ratio
    assign last    = (cnt_q >= (ratio_i - CNT_W'(1)));

    assign cmd_o.step = tick_i && !restart && last;
    assign cmd_o.dir  = dir_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
            dir_q <= DIR_DOWN;
        end else begin
            dir_q <= dir_i;
            if (restart) begin
                cnt_q <= '0;
            end else if (tick_i) begin
                cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
            end
        end
    end

    AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
        (dir_i != dir_q) |=> (cnt_q == '0)); // R8

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
        (!tick_i && (dir_i == dir_q)) |=> $stable(cnt_q)); // R7

endmodule

// File: rtl/dramp_level.sv
module dramp_level
    import dramp_pkg::*;
#(
    parameter int LVL_W   = DEF_LVL_W,
    parameter int LVL_TOP = DEF_LVL_TOP
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  step_cmd_t        cmd_i,
    output logic [LVL_W-1:0] level_o
);

    localparam logic [LVL_W-1:0] TOP = LVL_W'(LVL_TOP);

    logic [LVL_W-1:0] level_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            level_q <= '0;
        end else if (cmd_i.step) begin
            if (cmd_i.dir == DIR_UP) begin
                if (level_q < TOP) level_q <= level_q + LVL_W'(1);
            end else begin
                if (level_q != '0) level_q <= level_q - LVL_W'(1);
            end
        end
    end

    assign level_o = level_q;

    AST_LEVEL_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        level_q <= TOP); // R6

    AST_FLOOR_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (level_q == '0 && cmd_i.dir == DIR_DOWN) |=> (level_q == '0)); // R6

    AST_CEILING_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (level_q == TOP && cmd_i.dir == DIR_UP) |=> (level_q == TOP)); // R6

    AST_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        !cmd_i.step |=> $stable(level_q)); // R2

endmodule

// File: rtl/dramp_ctrl.sv
module dramp_ctrl
    import dramp_pkg::*;
#(
    parameter int LVL_W    = DEF_LVL_W,
    parameter int LVL_TOP  = DEF_LVL_TOP,
    parameter int UNIT_DIV = DEF_UNIT_DIV,
    parameter int DOWN_DIV = DEF_DOWN_DIV
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             period_tick_i,
    input  logic             fast_tick_i,
    input  logic             test_mode_i,
    input  logic [1:0]       rate_code_i,
    input  logic             duty_above_i,
    input  logic             band_low_i,
    input  logic             band_high_i,
    output logic [LVL_W-1:0] level_o
);

    localparam int CNT_W = $clog2(UNIT_DIV * 4 + 1);

    logic             sel_tick;
    dir_e             dir_w;
    logic [CNT_W-1:0] ratio_w;
    step_cmd_t        cmd_w;

    // Pacing source: the test tick replaces the period tick
    assign sel_tick = test_mode_i ? fast_tick_i : period_tick_i;

    dramp_dir_sel #(
        .CNT_W   (CNT_W),
        .UNIT_DIV(UNIT_DIV),
        .DOWN_DIV(DOWN_DIV)
    ) u_dir_sel (
        .band_low_i  (band_low_i),
        .band_high_i (band_high_i),
        .duty_above_i(duty_above_i),
        .rate_code_i (rate_code_i),
        .dir_o       (dir_w),
        .ratio_o     (ratio_w)
    );

    dramp_pacer #(
        .CNT_W(CNT_W)
    ) u_pacer (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_i (sel_tick),
        .dir_i  (dir_w),
        .ratio_i(ratio_w),
        .cmd_o  (cmd_w)
    );

    dramp_level #(
        .LVL_W  (LVL_W),
        .LVL_TOP(LVL_TOP)
    ) u_level (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .cmd_i  (cmd_w),
        .level_o(level_o)
    );

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !sel_tick |=> $stable(level_o)); // R7

    AST_LOW_BAND_NO_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
        band_low_i |=> (level_o <= $past(level_o))); // R5

endmodule

// File: tb/dramp_ctrl_bench.sv
`timescale 1ns/1ps
module dramp_ctrl_bench;

    typedef struct {
        int    val;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       period_tick = 1'b0;
    logic       fast_tick = 1'b0;
    logic       test_mode = 1'b0;
    logic [1:0] rate_code = 2'b11;
    logic       duty_above = 1'b0;
    logic       band_low = 1'b0;
    logic       band_high = 1'b0;
    logic [3:0] level;

    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    dramp_ctrl u_dramp_ctrl (
        .clk_i        (clk),
        .rst_i        (rst),
        .period_tick_i(period_tick),
        .fast_tick_i  (fast_tick),
        .test_mode_i  (test_mode),
        .rate_code_i  (rate_code),
        .duty_above_i (duty_above),
        .band_low_i   (band_low),
        .band_high_i  (band_high),
        .level_o      (level)
    );

    // Monitor: compare queued expectations on the falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t item;
            item = exp_q.pop_front();
            total++;
            if (int'(level) !== item.val) begin
                bad++;
                $display("FAIL %s: level=%0d expected=%0d", item.tag, level, item.val);
            end
        end
    end

    // One-cycle pulses on the chosen tick input; each is sampled by exactly one edge
    task automatic pulse(input bit fast, input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            if (fast) fast_tick = 1'b1; else period_tick = 1'b1;
            @(posedge clk);
            #1;
            fast_tick   = 1'b0;
            period_tick = 1'b0;
        end
    endtask

    task automatic expect_lvl(input int v, input string tag);
        exp_t item;
        item.val = v;
        item.tag = tag;
        exp_q.push_back(item);
        @(posedge clk);
        #1;
    endtask

    task automatic set_ctl(input bit above, input bit lo, input bit hi, input logic [1:0] code);
        @(posedge clk);
        #1;
        duty_above = above;
        band_low   = lo;
        band_high  = hi;
        rate_code  = code;
    endtask

    // Driver
    initial begin
        repeat (3) @(posedge clk);
        #1;
        expect_lvl(0, "R1 during reset");
        rst = 1'b0;
        expect_lvl(0, "R1 after reset");

        // Rise at 66 ticks per step (code 11)
        set_ctl(1, 0, 0, 2'b11);
        pulse(0, 65); expect_lvl(0, "R2 code11 one tick short");
        pulse(0, 1);  expect_lvl(1, "R9 step on completing tick");
        pulse(0, 66); expect_lvl(2, "R2 code11 second step");
        // 132 ticks (code 10)
        set_ctl(1, 0, 0, 2'b10);
        pulse(0, 131); expect_lvl(2, "R2 code10 one tick short");
        pulse(0, 1);   expect_lvl(3, "R2 code10 step");
        // 198 ticks (code 01)
        set_ctl(1, 0, 0, 2'b01);
        pulse(0, 197); expect_lvl(3, "R2 code01 one tick short");
        pulse(0, 1);   expect_lvl(4, "R2 code01 step");
        // 264 ticks (code 00)
        set_ctl(1, 0, 0, 2'b00);
        pulse(0, 263); expect_lvl(4, "R2 code00 one tick short");
        pulse(0, 1);   expect_lvl(5, "R2 code00 step");

        // Test mode: period tick ignored, fast tick paces
        set_ctl(1, 0, 0, 2'b11);
        @(posedge clk); #1; test_mode = 1'b1;
        pulse(0, 66); expect_lvl(5, "R7 period tick ignored in test mode");
        pulse(1, 65); expect_lvl(5, "R7 fast tick one short");
        pulse(1, 1);  expect_lvl(6, "R7 fast tick step");
        @(posedge clk); #1; test_mode = 1'b0;
        pulse(1, 66); expect_lvl(6, "R7 fast tick ignored in normal mode");

        // Falling at 4 ticks per step
        set_ctl(0, 0, 0, 2'b11);
        pulse(0, 3); expect_lvl(6, "R3 down one tick short");
        pulse(0, 1); expect_lvl(5, "R3 down step");
        pulse(0, 4); expect_lvl(4, "R3 down second step");

        // Direction reversal restarts the count
        set_ctl(1, 0, 0, 2'b11);
        pulse(0, 30); expect_lvl(4, "R8 partial up interval");
        set_ctl(0, 0, 0, 2'b11);
        pulse(0, 3); expect_lvl(4, "R8 down restarted from zero");
        pulse(0, 1); expect_lvl(3, "R8 down full interval");
        set_ctl(1, 0, 0, 2'b11);
        pulse(0, 65); expect_lvl(3, "R8 up restarted from zero");
        pulse(0, 1);  expect_lvl(4, "R8 up full interval");

        // High band: short interval in both directions
        set_ctl(1, 0, 1, 2'b00);
        pulse(0, 3);  expect_lvl(4, "R4 high band one short");
        pulse(0, 1);  expect_lvl(5, "R4 high band up step");
        pulse(0, 24); expect_lvl(11, "R4 high band reaches top");
        pulse(0, 4);  expect_lvl(11, "R6 ceiling holds");
        set_ctl(0, 0, 1, 2'b00);
        pulse(0, 4);  expect_lvl(10, "R4 high band down step");

        // Low band: forced down, compare bit ignored
        set_ctl(1, 1, 0, 2'b11);
        pulse(0, 40);  expect_lvl(0, "R5 low band drains to floor");
        pulse(0, 8);   expect_lvl(0, "R6 floor holds");
        set_ctl(1, 1, 0, 2'b00);
        pulse(0, 264); expect_lvl(0, "R5 low band never rises");

        // Back in band, rising again
        set_ctl(1, 0, 0, 2'b11);
        pulse(0, 66); expect_lvl(1, "R2 rise after low band");

        // Mid-run reset
        @(posedge clk); #1; rst = 1'b1;
        @(posedge clk); #1;
        expect_lvl(0, "R1 reset mid-run");
        rst = 1'b0;
        expect_lvl(0, "R1 level after mid-run reset");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule